// File: doc/BRIEF.md
# Register Rename Map with Readiness Scoreboard

This block is the register alias table of an out-of-order core. It keeps one logical-to-physical map for integer destinations and one for floating-point destinations. It also keeps a ready bit for every physical register and for every non-renamed miscellaneous register. All of these share one unified index space.

Each cycle the rename stage may offer one destination register. The block classifies the index and picks a fresh tag from the matching free-list handshake. It returns the new and the previous tag in the same cycle and commits the map change and the ready-bit clear at the clock edge.

Independent ports serve the rest of the core:
- A source lookup that sees the map as it stood before any same-cycle rename.
- A wakeup that marks a physical register ready.
- A readiness query.
- A direct entry write used for recovery.
- The smaller of the two free-list counts, which rename uses as its budget.

Top module: `rename_map_top`

## Requirements
- R1: Logical indices 0..7 are integer, 8..15 are floating point and 16..19 are miscellaneous. Physical tags 0..15 are integer, 16..31 are floating point and 32..35 are miscellaneous. After reset, integer logical i maps to tag i. Tags 0..7 are ready and tags 8..15 are not ready.
- R2: After reset, floating-point logical 8+k maps to tag 16+k. Tags 16..23 are ready, tags 24..31 are not ready, and miscellaneous tags 32..35 are ready.
- R3: Renaming a non-zero integer register pops the integer free list in that cycle. The previous tag is the old mapping and the new tag is the granted tag. From the next cycle, lookup returns the granted tag and that tag reads not ready.
- R4: A non-zero floating-point rename pops only the floating-point free list. An integer rename pops only the integer one. At most one list is popped per cycle.
- R5: Renaming the integer zero register (logical 0) or the floating-point zero register (logical 8) pops nothing and leaves the map unchanged. Both the new and the previous tag equal the current mapping of that register.
- R6: Renaming miscellaneous logical 16+m pops nothing and returns tag 32+m as both new and previous tag. That tag reads not ready from the next cycle.
- R7: When the needed free list offers no tag, rename_ready is low, nothing is popped and the map is unchanged.
- R8: A wakeup makes its tag read ready from the next cycle. If a rename clears the same tag in the same cycle, the tag stays not ready.
- R9: Lookup of a register being renamed in the same cycle returns the mapping from before the rename. Lookup of miscellaneous logical 16+m always returns 32+m.
- R10: A direct write sets the map entry of an integer or floating-point logical register from the next cycle. It takes precedence over a same-cycle rename of that entry. Direct writes to miscellaneous indices are ignored.
- R11: free_entries equals the smaller of the integer and floating-point free counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request present |
| renArch | input | 5 | Logical destination index |
| renReady | output | 1 | Request can complete this cycle |
| renNewTag | output | 6 | Newly assigned physical tag |
| renPrevTag | output | 6 | Tag the register held before |
| intFreeValid | input | 1 | Integer free list offers a tag |
| intFreeTag | input | 6 | Offered integer tag |
| intFreePop | output | 1 | Integer tag consumed |
| fpFreeValid | input | 1 | FP free list offers a tag |
| fpFreeTag | input | 6 | Offered FP tag |
| fpFreePop | output | 1 | FP tag consumed |
| intFreeCount | input | 6 | Integer free-list occupancy |
| fpFreeCount | input | 6 | FP free-list occupancy |
| freeEntries | output | 6 | Minimum of both counts |
| lookupArch | input | 5 | Source logical index |
| lookupTag | output | 6 | Current physical tag of source |
| wakeValid | input | 1 | Wakeup strobe |
| wakeTag | input | 6 | Tag to mark ready |
| queryTag | input | 6 | Tag whose ready bit is read |
| queryReady | output | 1 | Ready bit of queryTag |
| setValid | input | 1 | Direct map write strobe |
| setArch | input | 5 | Logical index to overwrite |
| setTag | input | 6 | Tag to store |

## Verification
The hardest situations are the same-cycle collisions: a wakeup arriving on the very tag a rename is clearing, and a recovery write landing on the entry a rename is updating. Neither ever arises from ordinary stream traffic. The bench therefore builds them directly. It hands the free list a tag that is also being woken in that cycle, and it raises the direct write on the renamed index while the rename fires. It then reads the outcome back through the query and lookup ports one cycle later.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  // Strobes sent from control to datapath for one rename.
  typedef struct packed {
    logic mapWr;   // update map entry of renamed logical register
    logic sbClr;   // clear ready bit of the assigned tag
  } rmapStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rmap_pkg::*;
#(
  parameter int LOG_INT  = 8,
  parameter int LOG_FP   = 8,
  parameter int PHYS_INT = 16,
  parameter int PHYS_FP  = 16,
  parameter int MISC     = 4,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 8,
  parameter int CNT_W    = 6,
  localparam int LT   = LOG_INT + LOG_FP,
  localparam int LTOT = LT + MISC,
  localparam int PT   = PHYS_INT + PHYS_FP,
  localparam int PALL = PT + MISC,
  localparam int LW   = $clog2(LTOT),
  localparam int PW   = $clog2(PALL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             renValid,
  input  logic [LW-1:0]    renArch,
  input  logic [PW-1:0]    curMap,
  output logic             renReady,
  output logic [PW-1:0]    renNewTag,
  output logic [PW-1:0]    renPrevTag,
  input  logic             intFreeValid,
  input  logic [PW-1:0]    intFreeTag,
  output logic             intFreePop,
  input  logic             fpFreeValid,
  input  logic [PW-1:0]    fpFreeTag,
  output logic             fpFreePop,
  input  logic [CNT_W-1:0] intFreeCount,
  input  logic [CNT_W-1:0] fpFreeCount,
  output logic [CNT_W-1:0] freeEntries,
  output rmapStrobe_t      strobe,
  output logic [PW-1:0]    clrTag
);
  logic needInt, needFp, wantWr, wantClr, fire;
  logic [PW-1:0] miscTag;

  assign miscTag = PW'(PT) + PW'(renArch) - PW'(LT);

  always_comb begin
    renReady   = 1'b1;
    renNewTag  = '0;
    renPrevTag = '0;
    needInt    = 1'b0;
    needFp     = 1'b0;
    wantWr     = 1'b0;
    wantClr    = 1'b0;
    clrTag     = '0;
    if (int'(renArch) >= LT) begin
      renNewTag  = miscTag;
      renPrevTag = miscTag;
      wantClr    = 1'b1;
      clrTag     = miscTag;
    end else if (renArch == LW'(INT_ZERO) || renArch == LW'(FP_ZERO)) begin
      renNewTag  = curMap;
      renPrevTag = curMap;
    end else if (int'(renArch) < LOG_INT) begin
      needInt    = 1'b1;
      renReady   = intFreeValid;
      renNewTag  = intFreeTag;
      renPrevTag = curMap;
      wantWr     = 1'b1;
      wantClr    = 1'b1;
      clrTag     = intFreeTag;
    end else begin
      needFp     = 1'b1;
      renReady   = fpFreeValid;
      renNewTag  = fpFreeTag;
      renPrevTag = curMap;
      wantWr     = 1'b1;
      wantClr    = 1'b1;
      clrTag     = fpFreeTag;
    end
  end

  assign fire         = renValid & renReady;
  assign intFreePop   = fire & needInt;
  assign fpFreePop    = fire & needFp;
  assign strobe.mapWr = fire & wantWr;
  assign strobe.sbClr = fire & wantClr;

  assign freeEntries = (intFreeCount < fpFreeCount) ? intFreeCount : fpFreeCount;

  // R4: never consume from both lists in one cycle
  p_single_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intFreePop, fpFreePop}));
  // R7: a pop only happens against an offered tag
  p_pop_needs_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intFreePop |-> intFreeValid) and (fpFreePop |-> fpFreeValid));
  // R3: granted integer tag lies in the integer physical range
  p_int_tag_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    intFreePop |-> (int'(intFreeTag) < PHYS_INT));
  // R4: granted FP tag lies in the FP physical range
  p_fp_tag_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    fpFreePop |-> (int'(fpFreeTag) >= PHYS_INT && int'(fpFreeTag) < PT));
  // R5: zero registers never allocate
  p_zero_no_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && (renArch == LW'(INT_ZERO) || renArch == LW'(FP_ZERO)))
      |-> (!intFreePop && !fpFreePop && !strobe.mapWr));
  // R6: misc renames stay outside the freeable range
  p_misc_tags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && int'(renArch) >= LT)
      |-> (int'(renPrevTag) >= PT && !intFreePop && !fpFreePop));
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rmap_pkg::*;
#(
  parameter int LOG_INT  = 8,
  parameter int LOG_FP   = 8,
  parameter int PHYS_INT = 16,
  parameter int PHYS_FP  = 16,
  parameter int MISC     = 4,
  localparam int LT   = LOG_INT + LOG_FP,
  localparam int LTOT = LT + MISC,
  localparam int PT   = PHYS_INT + PHYS_FP,
  localparam int PALL = PT + MISC,
  localparam int LW   = $clog2(LTOT),
  localparam int PW   = $clog2(PALL),
  localparam int MW   = $clog2(LT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rmapStrobe_t   strobe,
  input  logic [PW-1:0] wrTag,
  input  logic [PW-1:0] clrTag,
  input  logic [LW-1:0] renArch,
  output logic [PW-1:0] curMap,
  input  logic [LW-1:0] lookupArch,
  output logic [PW-1:0] lookupTag,
  input  logic          wakeValid,
  input  logic [PW-1:0] wakeTag,
  input  logic [PW-1:0] queryTag,
  output logic          queryReady,
  input  logic          setValid,
  input  logic [LW-1:0] setArch,
  input  logic [PW-1:0] setTag
);
  logic [PW-1:0]   mapQ [LT];
  logic [LT-1:0]   setHit, renHit;
  logic [PALL-1:0] readyQ;

  for (genvar g = 0; g < LT; g++) begin : g_map
    localparam logic [PW-1:0] RST_TAG =
      PW'((g < LOG_INT) ? g : (PHYS_INT + g - LOG_INT));
    assign setHit[g] = setValid && (setArch == LW'(g));
    assign renHit[g] = strobe.mapWr && (renArch == LW'(g));
    always_ff @(posedge clk) begin
      if (!rstN)          mapQ[g] <= RST_TAG;
      else if (setHit[g]) mapQ[g] <= setTag;
      else if (renHit[g]) mapQ[g] <= wrTag;
    end
  end

  for (genvar b = 0; b < PALL; b++) begin : g_sb
    localparam bit RST_RDY = (b < LOG_INT) ||
                             (b >= PHYS_INT && b < PHYS_INT + LOG_FP) ||
                             (b >= PT);
    always_ff @(posedge clk) begin
      if (!rstN)                                    readyQ[b] <= RST_RDY;
      else if (strobe.sbClr && clrTag == PW'(b))    readyQ[b] <= 1'b0;
      else if (wakeValid && wakeTag == PW'(b))      readyQ[b] <= 1'b1;
    end
  end

  assign curMap = (int'(renArch) < LT) ? mapQ[renArch[MW-1:0]] : '0;

  always_comb begin
    if (int'(lookupArch) < LT) lookupTag = mapQ[lookupArch[MW-1:0]];
    else                       lookupTag = PW'(PT) + PW'(lookupArch) - PW'(LT);
  end

  assign queryReady = (int'(queryTag) < PALL) ? readyQ[queryTag] : 1'b0;

  // R8: a rename clear beats any same-cycle wakeup
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sbClr |=> !readyQ[$past(clrTag)]);
  // R8: an uncontested wakeup lands
  p_wake_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeValid && int'(wakeTag) < PALL && !(strobe.sbClr && clrTag == wakeTag))
      |=> readyQ[$past(wakeTag)]);
  // R10: direct write wins over rename on the same entry
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && int'(setArch) < LT) |=> mapQ[$past(setArch[MW-1:0])] == $past(setTag));
  // R3: uncontested rename write reaches the map
  p_map_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mapWr && !(setValid && setArch == renArch))
      |=> mapQ[$past(renArch[MW-1:0])] == $past(wrTag));
endmodule

// File: rtl/rename_map_top.sv
module rename_map_top
  import rmap_pkg::*;
#(
  parameter int LOG_INT  = 8,
  parameter int LOG_FP   = 8,
  parameter int PHYS_INT = 16,
  parameter int PHYS_FP  = 16,
  parameter int MISC     = 4,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 8,
  parameter int CNT_W    = 6,
  localparam int LTOT = LOG_INT + LOG_FP + MISC,
  localparam int PALL = PHYS_INT + PHYS_FP + MISC,
  localparam int LW   = $clog2(LTOT),
  localparam int PW   = $clog2(PALL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             renValid,
  input  logic [LW-1:0]    renArch,
  output logic             renReady,
  output logic [PW-1:0]    renNewTag,
  output logic [PW-1:0]    renPrevTag,
  input  logic             intFreeValid,
  input  logic [PW-1:0]    intFreeTag,
  output logic             intFreePop,
  input  logic             fpFreeValid,
  input  logic [PW-1:0]    fpFreeTag,
  output logic             fpFreePop,
  input  logic [CNT_W-1:0] intFreeCount,
  input  logic [CNT_W-1:0] fpFreeCount,
  output logic [CNT_W-1:0] freeEntries,
  input  logic [LW-1:0]    lookupArch,
  output logic [PW-1:0]    lookupTag,
  input  logic             wakeValid,
  input  logic [PW-1:0]    wakeTag,
  input  logic [PW-1:0]    queryTag,
  output logic             queryReady,
  input  logic             setValid,
  input  logic [LW-1:0]    setArch,
  input  logic [PW-1:0]    setTag
);
  rmapStrobe_t   strobe;
  logic [PW-1:0] curMap, clrTag;

  rename_ctrl #(
    .LOG_INT(LOG_INT), .LOG_FP(LOG_FP), .PHYS_INT(PHYS_INT), .PHYS_FP(PHYS_FP),
    .MISC(MISC), .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renArch(renArch),
    .curMap(curMap), .renReady(renReady), .renNewTag(renNewTag),
    .renPrevTag(renPrevTag), .intFreeValid(intFreeValid), .intFreeTag(intFreeTag),
    .intFreePop(intFreePop), .fpFreeValid(fpFreeValid), .fpFreeTag(fpFreeTag),
    .fpFreePop(fpFreePop), .intFreeCount(intFreeCount), .fpFreeCount(fpFreeCount),
    .freeEntries(freeEntries), .strobe(strobe), .clrTag(clrTag)
  );

  rename_datapath #(
    .LOG_INT(LOG_INT), .LOG_FP(LOG_FP), .PHYS_INT(PHYS_INT), .PHYS_FP(PHYS_FP),
    .MISC(MISC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrTag(renNewTag), .clrTag(clrTag),
    .renArch(renArch), .curMap(curMap), .lookupArch(lookupArch),
    .lookupTag(lookupTag), .wakeValid(wakeValid), .wakeTag(wakeTag),
    .queryTag(queryTag), .queryReady(queryReady), .setValid(setValid),
    .setArch(setArch), .setTag(setTag)
  );
endmodule

// File: tb/rename_map_top_tb.sv
`timescale 1ns/1ps
module rename_map_top_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       renValid;
  logic [4:0] renArch;
  logic       renReady;
  logic [5:0] renNewTag, renPrevTag;
  logic       intFreeValid, fpFreeValid;
  logic [5:0] intFreeTag, fpFreeTag;
  logic       intFreePop, fpFreePop;
  logic [5:0] intFreeCount, fpFreeCount, freeEntries;
  logic [4:0] lookupArch;
  logic [5:0] lookupTag;
  logic       wakeValid;
  logic [5:0] wakeTag, queryTag;
  logic       queryReady;
  logic       setValid;
  logic [4:0] setArch;
  logic [5:0] setTag;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  rename_map_top u_dut (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renArch(renArch),
    .renReady(renReady), .renNewTag(renNewTag), .renPrevTag(renPrevTag),
    .intFreeValid(intFreeValid), .intFreeTag(intFreeTag), .intFreePop(intFreePop),
    .fpFreeValid(fpFreeValid), .fpFreeTag(fpFreeTag), .fpFreePop(fpFreePop),
    .intFreeCount(intFreeCount), .fpFreeCount(fpFreeCount), .freeEntries(freeEntries),
    .lookupArch(lookupArch), .lookupTag(lookupTag), .wakeValid(wakeValid),
    .wakeTag(wakeTag), .queryTag(queryTag), .queryReady(queryReady),
    .setValid(setValid), .setArch(setArch), .setTag(setTag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    renValid = 0; renArch = 0; intFreeValid = 0; intFreeTag = 0;
    fpFreeValid = 0; fpFreeTag = 0; wakeValid = 0; wakeTag = 0;
    setValid = 0; setArch = 0; setTag = 0;
  endtask

  // advance through one clock edge, ending just after the next falling edge
  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic lookupIs(input string req, input int arch, input int exp);
    lookupArch = 5'(arch); #1; chk(req, int'(lookupTag), exp);
  endtask

  task automatic readyIs(input string req, input int tag, input int exp);
    queryTag = 6'(tag); #1; chk(req, int'(queryReady), exp);
  endtask

  task automatic testReset();
    for (int l = 0; l < 8; l++)  lookupIs("R1 int map", l, l);
    for (int l = 8; l < 16; l++) lookupIs("R2 fp map", l, 16 + l - 8);
    for (int l = 16; l < 20; l++) lookupIs("R9 misc lookup", l, 32 + l - 16);
    for (int p = 0; p < 16; p++) readyIs("R1 int ready", p, (p < 8) ? 1 : 0);
    for (int p = 16; p < 32; p++) readyIs("R2 fp ready", p, (p < 24) ? 1 : 0);
    for (int p = 32; p < 36; p++) readyIs("R2 misc ready", p, 1);
  endtask

  task automatic testIntRename();
    renValid = 1; renArch = 3; intFreeValid = 1; intFreeTag = 9;
    fpFreeValid = 1; fpFreeTag = 30; lookupArch = 3; #1;
    chk("R3 ready", int'(renReady), 1);
    chk("R3 new", int'(renNewTag), 9);
    chk("R3 prev", int'(renPrevTag), 3);
    chk("R3 int pop", int'(intFreePop), 1);
    chk("R4 no fp pop", int'(fpFreePop), 0);
    chk("R9 pre-rename lookup", int'(lookupTag), 3);
    step();
    lookupIs("R3 map updated", 3, 9);
    readyIs("R3 tag not ready", 9, 0);
    wakeValid = 1; wakeTag = 9;
    step();
    readyIs("R8 wakeup", 9, 1);
  endtask

  task automatic testFpRename();
    renValid = 1; renArch = 9; fpFreeValid = 1; fpFreeTag = 24;
    intFreeValid = 1; intFreeTag = 5; #1;
    chk("R4 new", int'(renNewTag), 24);
    chk("R4 prev", int'(renPrevTag), 17);
    chk("R4 fp pop", int'(fpFreePop), 1);
    chk("R4 no int pop", int'(intFreePop), 0);
    step();
    lookupIs("R4 fp map updated", 9, 24);
    lookupIs("R4 int map untouched", 5, 5);
  endtask

  task automatic testZero();
    renValid = 1; renArch = 0; intFreeValid = 0; #1;
    chk("R5 int zero ready", int'(renReady), 1);
    chk("R5 int zero new", int'(renNewTag), 0);
    chk("R5 int zero prev", int'(renPrevTag), 0);
    chk("R5 int zero no pop", int'(intFreePop), 0);
    step();
    lookupIs("R5 int zero map", 0, 0);
    renValid = 1; renArch = 8; fpFreeValid = 1; fpFreeTag = 25; #1;
    chk("R5 fp zero new", int'(renNewTag), 16);
    chk("R5 fp zero prev", int'(renPrevTag), 16);
    chk("R5 fp zero no pop", int'(fpFreePop), 0);
    step();
    lookupIs("R5 fp zero map", 8, 16);
  endtask

  task automatic testMisc();
    renValid = 1; renArch = 17; intFreeValid = 1; intFreeTag = 12; #1;
    chk("R6 misc ready", int'(renReady), 1);
    chk("R6 misc new", int'(renNewTag), 33);
    chk("R6 misc prev", int'(renPrevTag), 33);
    chk("R6 misc no pop", int'(intFreePop) + int'(fpFreePop), 0);
    step();
    readyIs("R6 misc not ready", 33, 0);
    readyIs("R6 neighbour ready", 34, 1);
    lookupIs("R9 misc lookup after", 17, 33);
  endtask

  task automatic testStall();
    renValid = 1; renArch = 2; intFreeValid = 0; fpFreeValid = 1; fpFreeTag = 26; #1;
    chk("R7 int stall", int'(renReady), 0);
    chk("R7 no pop", int'(intFreePop) + int'(fpFreePop), 0);
    step();
    lookupIs("R7 map kept", 2, 2);
    renValid = 1; renArch = 12; intFreeValid = 1; intFreeTag = 13; fpFreeValid = 0; #1;
    chk("R7 fp stall", int'(renReady), 0);
    chk("R7 fp no pop", int'(intFreePop) + int'(fpFreePop), 0);
    step();
    lookupIs("R7 fp map kept", 12, 20);
  endtask

  task automatic testCollide();
    renValid = 1; renArch = 5; intFreeValid = 1; intFreeTag = 10;
    wakeValid = 1; wakeTag = 10;
    step();
    readyIs("R8 clear beats wakeup", 10, 0);
    wakeValid = 1; wakeTag = 11;
    step();
    readyIs("R8 plain wakeup", 11, 1);
  endtask

  task automatic testSet();
    setValid = 1; setArch = 6; setTag = 14;
    step();
    lookupIs("R10 direct write", 6, 14);
    setValid = 1; setArch = 18; setTag = 3;
    step();
    lookupIs("R10 misc write ignored", 18, 34);
    lookupIs("R10 int entry untouched", 2, 2);
    renValid = 1; renArch = 7; intFreeValid = 1; intFreeTag = 12;
    setValid = 1; setArch = 7; setTag = 13;
    step();
    lookupIs("R10 write beats rename", 7, 13);
  endtask

  task automatic testCount();
    intFreeCount = 5; fpFreeCount = 3; #1;
    chk("R11 min fp", int'(freeEntries), 3);
    intFreeCount = 2; fpFreeCount = 7; #1;
    chk("R11 min int", int'(freeEntries), 2);
    intFreeCount = 4; fpFreeCount = 4; #1;
    chk("R11 equal", int'(freeEntries), 4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle();
    lookupArch = 0; queryTag = 0; intFreeCount = 0; fpFreeCount = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    testReset();
    testIntRename();
    testFpRename();
    testZero();
    testMisc();
    testStall();
    testCollide();
    testSet();
    testCount();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule